// File: doc/BRIEF.md
# Non-Destructive Multi-Memory RAM Self-Test Engine

This block tests every word of one or more attached single-port synchronous RAMs and keeps the data that was in them. At each location it first reads the stored word into a holding register. It then writes an alternating bit pattern, reads it back and compares it. Next it writes the bitwise inverse, reads that back and compares it. Last it writes the held word back. Each bit is therefore shown to hold both a 0 and a 1, and the memory contents are the same after the test as before it.

Memories are tested one at a time, from index 0 upwards, and addresses within a memory from 0 upwards. A new memory is started only after every address of the previous one has passed. On the first miscompare the engine still restores the word at that location, then stops. It raises `fail` and holds the memory index, the address, the expected data and the data read back. When the sequence ends, `done` pulses for one cycle. `pass` or `fail` then stays valid until the next start.

The controller is a single state machine with these states:

| State | Action | Next state |
|---|---|---|
| IDLE | Waits | RD_ORIG on `start` |
| RD_ORIG | Presents the read address | WR_PAT |
| WR_PAT | Captures the original word and writes the pattern | RD_PAT |
| RD_PAT | Reads the location | CHK_PAT |
| CHK_PAT | Compares with the pattern | WR_INV if equal, RESTORE if not |
| WR_INV | Writes the inverse pattern | RD_INV |
| RD_INV | Reads the location | CHK_INV |
| CHK_INV | Compares with the inverse | RESTORE |
| RESTORE | Writes the held word back | FINISH after a miscompare or at the last location of the last memory, otherwise RD_ORIG at the next location |
| FINISH | Pulses `done` | IDLE |

Top module: `ram_selftest_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `fail` are low and no memory write enable is asserted. This stays so until `start` is seen.
- R2: Each location takes exactly 8 cycles. Its three writes are, in order:
  - the pattern, whose bit i is 1 exactly when i is odd (0xAA for 8 bits);
  - the bitwise inverse (0x55);
  - the original word.
- R3: A run with no miscompare leaves every word of every memory equal to its value before the run.
- R4: Memories are visited in ascending index order and addresses in ascending order from 0. No write reaches memory k+1 before memory k has finished, and at most one write enable is high in any cycle.
- R5: `done` is high for exactly one cycle, `NUM_MEMS*2^ADDR_W*8+1` cycles after the edge that accepts `start` on a clean run. `busy` is low in that cycle.
- R6: After a clean run `pass` is 1 and `fail` is 0. Both hold until the next accepted start. `pass` and `fail` are never high together.
- R7: A miscompare after the pattern write stops the run after the restore write, 5 cycles into that location. `fail` rises, `fail_mem` and `fail_addr` name the location, `fail_exp` is the pattern and `fail_got` is the data read.
- R8: A miscompare after the inverse write stops the run after the restore write, 8 cycles into that location. `fail_exp` is the inverse pattern and `fail_got` is the data read.
- R9: A `start` that arrives while `busy` is high has no effect on the run length or the result.
- R10: After a failure, no location after the failing one is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, accepted only in IDLE |
| busy | output | 1 | Test sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last run found no miscompare |
| fail | output | 1 | Last run stopped on a miscompare |
| fail_mem | output | MEM_W | Memory index of the first failure |
| fail_addr | output | ADDR_W | Address of the first failure |
| fail_exp | output | DATA_W | Expected word at the failure |
| fail_got | output | DATA_W | Word read at the failure |
| mem_addr | output | NUM_MEMS*ADDR_W | Address for each memory, memory k in slice k |
| mem_we | output | NUM_MEMS | Write enable for each memory |
| mem_wdata | output | NUM_MEMS*DATA_W | Write data for each memory |
| mem_rdata | input | NUM_MEMS*DATA_W | Read data from each memory, one cycle after its address |

## Verification
The bench builds the engine with `NUM_MEMS=2`, `ADDR_W=3` and `DATA_W=8`, so a clean run takes 129 cycles. With two memories, the move from the last address of memory 0 to the first address of memory 1 can be checked, along with the rule that memory 1 is written only after memory 0 is done. The 8-bit width makes the pattern 0xAA and the inverse 0x55. Stuck-at faults injected into the bench memory model then hit each compare stage on a chosen memory and address, which puts the latched failure fields and the untouched later locations within reach.

// File: rtl/rst_pkg.sv
package rst_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ORIG,
        ST_WR_PAT,
        ST_RD_PAT,
        ST_CHK_PAT,
        ST_WR_INV,
        ST_RD_INV,
        ST_CHK_INV,
        ST_RESTORE,
        ST_FINISH
    } rst_state_e;

endpackage

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       mismatch,
    input  logic       err_flag,
    input  logic       last_loc,
    output rst_state_e state,
    output logic       start_acc,
    output logic       step,
    output logic       wr_any,
    output logic       busy,
    output logic       done,
    output logic       pass,
    output logic       fail
);

    rst_state_e nxt;
    logic       to_finish;

    assign to_finish = (state == ST_RESTORE) && (err_flag || last_loc);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_RD_ORIG;
            ST_RD_ORIG: nxt = ST_WR_PAT;
            ST_WR_PAT:  nxt = ST_RD_PAT;
            ST_RD_PAT:  nxt = ST_CHK_PAT;
            ST_CHK_PAT: nxt = mismatch ? ST_RESTORE : ST_WR_INV;
            ST_WR_INV:  nxt = ST_RD_INV;
            ST_RD_INV:  nxt = ST_CHK_INV;
            ST_CHK_INV: nxt = ST_RESTORE;
            ST_RESTORE: nxt = (err_flag || last_loc) ? ST_FINISH : ST_RD_ORIG;
            ST_FINISH:  nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pass  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            state <= nxt;
            if (start_acc) begin
                pass <= 1'b0;
                fail <= 1'b0;
            end else if (to_finish) begin
                pass <= !err_flag;
                fail <= err_flag;
            end
        end
    end

    always_comb begin
        start_acc = (state == ST_IDLE) && start;
        step      = (state == ST_RESTORE) && !err_flag && !last_loc;
        wr_any    = (state == ST_WR_PAT) || (state == ST_WR_INV) || (state == ST_RESTORE);
        busy      = (state != ST_IDLE) && (state != ST_FINISH);
        done      = (state == ST_FINISH);
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done)); // R9
    AST_PASS_FAIL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail)); // R6

endmodule

// File: rtl/rst_loc_walker.sv
module rst_loc_walker #(
    parameter int NUM_MEMS = 2,
    parameter int ADDR_W   = 8,
    parameter int MEM_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic [MEM_W-1:0]  mem_idx,
    output logic              last_loc
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
    localparam logic [MEM_W-1:0]  LAST_MEM  = MEM_W'(NUM_MEMS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr    <= '0;
            mem_idx <= '0;
        end else if (clear) begin
            addr    <= '0;
            mem_idx <= '0;
        end else if (step) begin
            if (addr == LAST_ADDR) begin
                addr    <= '0;
                mem_idx <= mem_idx + MEM_W'(1);
            end else begin
                addr    <= addr + ADDR_W'(1);
            end
        end
    end

    assign last_loc = (addr == LAST_ADDR) && (mem_idx == LAST_MEM);

    AST_ORDERED_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> ((addr == ADDR_W'($past(addr) + ADDR_W'(1))) && (mem_idx == $past(mem_idx)))
              || ((addr == '0) && (mem_idx == MEM_W'($past(mem_idx) + MEM_W'(1))))); // R4
    AST_LOC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> ($stable(addr) && $stable(mem_idx))); // R2

endmodule

// File: rtl/rst_cmp_path.sv
module rst_cmp_path
    import rst_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int MEM_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rst_state_e        state,
    input  logic              clear,
    input  logic [DATA_W-1:0] rdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MEM_W-1:0]  mem_idx,
    output logic [DATA_W-1:0] wdata,
    output logic              mismatch,
    output logic              err_flag,
    output logic [MEM_W-1:0]  fail_mem,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_got
);

    function automatic logic [DATA_W-1:0] alt_pattern();
        logic [DATA_W-1:0] p;
        for (int i = 0; i < DATA_W; i++) p[i] = (i % 2 == 1);
        return p;
    endfunction

    localparam logic [DATA_W-1:0] PAT  = alt_pattern();
    localparam logic [DATA_W-1:0] IPAT = ~PAT;

    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] expect_w;
    logic              chk;

    always_comb begin
        chk      = (state == ST_CHK_PAT) || (state == ST_CHK_INV);
        expect_w = (state == ST_CHK_INV) ? IPAT : PAT;
        mismatch = chk && (rdata != expect_w);
        unique case (state)
            ST_WR_PAT:  wdata = PAT;
            ST_WR_INV:  wdata = IPAT;
            ST_RESTORE: wdata = hold_q;
            default:    wdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            err_flag  <= 1'b0;
            fail_mem  <= '0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_got  <= '0;
        end else begin
            if (state == ST_WR_PAT) hold_q <= rdata;
            if (clear) begin
                err_flag  <= 1'b0;
                fail_mem  <= '0;
                fail_addr <= '0;
                fail_exp  <= '0;
                fail_got  <= '0;
            end else if (mismatch && !err_flag) begin
                err_flag  <= 1'b1;
                fail_mem  <= mem_idx;
                fail_addr <= addr;
                fail_exp  <= expect_w;
                fail_got  <= rdata;
            end
        end
    end

    AST_FAIL_RECORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clear) |=> ($stable(fail_addr) && $stable(fail_got) && $stable(fail_mem))); // R7
    AST_RESTORE_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> (state == ST_RESTORE)); // R8

endmodule

// File: rtl/rst_port_mux.sv
module rst_port_mux #(
    parameter int NUM_MEMS = 2,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int MEM_W    = 1
) (
    input  logic [MEM_W-1:0]           mem_idx,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_any,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_MEMS*DATA_W-1:0] mem_rdata,
    output logic [NUM_MEMS*ADDR_W-1:0] mem_addr,
    output logic [NUM_MEMS-1:0]        mem_we,
    output logic [NUM_MEMS*DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0]          rdata_sel
);

    logic [DATA_W-1:0] rd_arr [NUM_MEMS];

    for (genvar k = 0; k < NUM_MEMS; k++) begin : g_port
        logic sel;
        assign sel                          = (mem_idx == MEM_W'(k));
        assign mem_addr[k*ADDR_W +: ADDR_W] = sel ? addr : '0;
        assign mem_we[k]                    = sel && wr_any;
        assign mem_wdata[k*DATA_W +: DATA_W] = sel ? wdata : '0;
        assign rd_arr[k]                    = mem_rdata[k*DATA_W +: DATA_W];
    end

    assign rdata_sel = rd_arr[mem_idx];

endmodule

// File: rtl/ram_selftest_engine.sv
module ram_selftest_engine
    import rst_pkg::*;
#(
    parameter int NUM_MEMS = 2,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    localparam int MEM_W   = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    output logic                       busy,
    output logic                       done,
    output logic                       pass,
    output logic                       fail,
    output logic [MEM_W-1:0]           fail_mem,
    output logic [ADDR_W-1:0]          fail_addr,
    output logic [DATA_W-1:0]          fail_exp,
    output logic [DATA_W-1:0]          fail_got,
    output logic [NUM_MEMS*ADDR_W-1:0] mem_addr,
    output logic [NUM_MEMS-1:0]        mem_we,
    output logic [NUM_MEMS*DATA_W-1:0] mem_wdata,
    input  logic [NUM_MEMS*DATA_W-1:0] mem_rdata
);

    rst_state_e        state;
    logic              start_acc, step, wr_any, mismatch, err_flag, last_loc;
    logic [ADDR_W-1:0] addr;
    logic [MEM_W-1:0]  mem_idx;
    logic [DATA_W-1:0] wdata, rdata_sel;

    rst_seq_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .mismatch(mismatch),
        .err_flag(err_flag), .last_loc(last_loc), .state(state),
        .start_acc(start_acc), .step(step), .wr_any(wr_any),
        .busy(busy), .done(done), .pass(pass), .fail(fail)
    );

    rst_loc_walker #(.NUM_MEMS(NUM_MEMS), .ADDR_W(ADDR_W), .MEM_W(MEM_W)) i_walk (
        .clk(clk), .rst_n(rst_n), .clear(start_acc), .step(step),
        .addr(addr), .mem_idx(mem_idx), .last_loc(last_loc)
    );

    rst_cmp_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_W(MEM_W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .state(state), .clear(start_acc),
        .rdata(rdata_sel), .addr(addr), .mem_idx(mem_idx), .wdata(wdata),
        .mismatch(mismatch), .err_flag(err_flag), .fail_mem(fail_mem),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_got(fail_got)
    );

    rst_port_mux #(.NUM_MEMS(NUM_MEMS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_W(MEM_W)) i_mux (
        .mem_idx(mem_idx), .addr(addr), .wr_any(wr_any), .wdata(wdata),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .rdata_sel(rdata_sel)
    );

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_we == '0)); // R1
    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_we)); // R4
    AST_FAIL_AT_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> done); // R7

endmodule

// File: tb/test_ram_selftest_engine.sv
`timescale 1ns/1ps
module test_ram_selftest_engine;

    localparam int NM = 2;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;
    localparam int CLEAN_CYC = NM * DEPTH * 8 + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, pass, fail;
    logic [0:0] fail_mem;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_got;
    logic [NM*AW-1:0] mem_addr;
    logic [NM-1:0] mem_we;
    logic [NM*DW-1:0] mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    ram_selftest_engine #(.NUM_MEMS(NM), .ADDR_W(AW), .DATA_W(DW)) i_ram_selftest_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_mem(fail_mem), .fail_addr(fail_addr),
        .fail_exp(fail_exp), .fail_got(fail_got), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // bench memory model with stuck-at fault masks
    logic [DW-1:0] mem  [NM][DEPTH];
    logic [DW-1:0] init [NM][DEPTH];
    logic [DW-1:0] sa1  [NM][DEPTH];
    logic [DW-1:0] sa0  [NM][DEPTH];
    logic [DW-1:0] rd   [NM];
    int            wcnt [NM][DEPTH];
    logic [DW-1:0] wlog [3];
    int            wtotal;
    logic          saw_m1, order_err, load;

    for (genvar g = 0; g < NM; g++) begin : g_rd
        assign mem_rdata[g*DW +: DW] = rd[g];
    end

    always @(posedge clk) begin
        if (load) begin
            for (int m = 0; m < NM; m++)
                for (int a = 0; a < DEPTH; a++) begin
                    mem[m][a]  <= init[m][a];
                    wcnt[m][a] <= 0;
                end
            wtotal    <= 0;
            saw_m1    <= 1'b0;
            order_err <= 1'b0;
        end else begin
            for (int m = 0; m < NM; m++) begin
                rd[m] <= mem[m][mem_addr[m*AW +: AW]];
                if (mem_we[m]) begin
                    mem[m][mem_addr[m*AW +: AW]] <=
                        (mem_wdata[m*DW +: DW] | sa1[m][mem_addr[m*AW +: AW]])
                        & ~sa0[m][mem_addr[m*AW +: AW]];
                    wcnt[m][mem_addr[m*AW +: AW]] <= wcnt[m][mem_addr[m*AW +: AW]] + 1;
                    if (wtotal < 3) wlog[wtotal] <= mem_wdata[m*DW +: DW];
                    wtotal <= wtotal + 1;
                    if (m == 0 && saw_m1) order_err <= 1'b1;
                    if (m == 1) saw_m1 <= 1'b1;
                end
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [DW-1:0] seed);
        for (int m = 0; m < NM; m++)
            for (int a = 0; a < DEPTH; a++) begin
                init[m][a] = DW'(seed + m * 8'h3B + a * 8'h17);
                sa1[m][a]  = '0;
                sa0[m][a]  = '0;
            end
    endtask

    task automatic do_load();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic run(input int pulse_at, output int cyc);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start = (cyc == pulse_at);
        end
        start = 1'b0;
        if (cyc >= 3000) check(1'b0, "watchdog", cyc, 0);
    endtask

    function automatic int contents_diff();
        int d = 0;
        for (int m = 0; m < NM; m++)
            for (int a = 0; a < DEPTH; a++)
                if (mem[m][a] !== init[m][a]) d++;
        return d;
    endfunction

    task automatic t_reset();
        check(!busy && !done, "R1 busy/done", {busy, done}, 0);
        check(!pass && !fail, "R1 pass/fail", {pass, fail}, 0);
        check(mem_we == '0, "R1 we", mem_we, 0);
    endtask

    task automatic t_clean(input logic [DW-1:0] seed, input int pulse_at);
        int cyc;
        fill(seed);
        do_load();
        run(pulse_at, cyc);
        if (pulse_at > 0) check(cyc == CLEAN_CYC, "R9 length with start while busy", cyc, CLEAN_CYC);
        else              check(cyc == CLEAN_CYC, "R5 run length", cyc, CLEAN_CYC);
        check(busy == 1'b0, "R5 busy low at done", busy, 0);
        check(pass && !fail, "R6 clean result", {pass, fail}, 2);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", done, 0);
        check(contents_diff() == 0, "R3 contents preserved", contents_diff(), 0);
        check(order_err == 1'b0, "R4 memory order", order_err, 0);
        check(wtotal == 3 * NM * DEPTH, "R2 write count", wtotal, 3 * NM * DEPTH);
        check(wlog[0] == 8'hAA, "R2 first write pattern", wlog[0], 8'hAA);
        check(wlog[1] == 8'h55, "R2 second write inverse", wlog[1], 8'h55);
        check(wlog[2] == init[0][0], "R2 third write original", wlog[2], init[0][0]);
        repeat (5) @(negedge clk);
        check(pass && !fail, "R6 result held", {pass, fail}, 2);
    endtask

    task automatic t_stuck_pat();
        int cyc;
        int exp_cyc;
        fill(8'h21);
        init[1][5] = init[1][5] | 8'h01;
        sa1[1][5]  = 8'h01;
        do_load();
        exp_cyc = 1 + 8 * (DEPTH + 5) + 5;
        run(0, cyc);
        check(cyc == exp_cyc, "R7 stop cycle", cyc, exp_cyc);
        check(fail && !pass, "R7 fail flag", {pass, fail}, 1);
        check(fail_mem == 1'b1, "R7 fail_mem", fail_mem, 1);
        check(fail_addr == 3'd5, "R7 fail_addr", fail_addr, 5);
        check(fail_exp == 8'hAA, "R7 fail_exp", fail_exp, 8'hAA);
        check(fail_got == 8'hAB, "R7 fail_got", fail_got, 8'hAB);
        @(negedge clk);
        check(contents_diff() == 0, "R3 restore after miscompare", contents_diff(), 0);
        check(wcnt[1][5] == 2, "R7 pattern then restore", wcnt[1][5], 2);
        check(wcnt[1][6] == 0 && wcnt[1][7] == 0, "R10 later untouched",
              wcnt[1][6] + wcnt[1][7], 0);
    endtask

    task automatic t_stuck_inv();
        int cyc;
        int exp_cyc;
        fill(8'h90);
        init[0][2] = init[0][2] & 8'hFE;
        sa0[0][2]  = 8'h01;
        do_load();
        exp_cyc = 1 + 8 * 2 + 8;
        run(0, cyc);
        check(cyc == exp_cyc, "R8 stop cycle", cyc, exp_cyc);
        check(fail && !pass, "R8 fail flag", {pass, fail}, 1);
        check(fail_mem == 1'b0, "R8 fail_mem", fail_mem, 0);
        check(fail_addr == 3'd2, "R8 fail_addr", fail_addr, 2);
        check(fail_exp == 8'h55, "R8 fail_exp", fail_exp, 8'h55);
        check(fail_got == 8'h54, "R8 fail_got", fail_got, 8'h54);
        @(negedge clk);
        check(contents_diff() == 0, "R3 restore after inverse miss", contents_diff(), 0);
        check(wcnt[0][3] == 0 && wcnt[1][0] == 0, "R10 later untouched",
              wcnt[0][3] + wcnt[1][0], 0);
    endtask

    initial begin
        load = 1'b0;
        fill(8'h00);
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_clean(8'h13, 0);
        t_clean(8'hF0, 0);
        t_stuck_pat();
        t_stuck_inv();
        t_clean(8'h5A, 20);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule